// File: doc/BRIEF.md
# CAN Data-Phase Bit Timing Generator

This block turns a module clock into the quantum and segment timing of one CAN data-phase bit. A prescaler divides the clock into time quanta; a quantum counter then walks each bit through a one-quantum sync segment, a first segment that holds the propagation and first phase parts, and a second segment that holds the second phase part. It raises four single-clock strobes: a quantum tick, a bit start, the sample point and a next-bit-ready strobe.

The three timing fields are loaded through a write port. The port is locked unless both the configuration-enable bit and the init bit are high. While init is high, or the run enable is low, both counters sit at zero and no strobe is raised. When the block is released, the first bit starts on the first clock and uses the current fields. A field change can therefore only take hold at a fresh bit start, after init has been cleared.

Top module: `can_bittime_gen`

## Requirements
- R1: A time quantum lasts (prescaler field + 1) clocks, from 1 to 32. `tq_tick` is high on the last clock of every quantum.
- R2: A bit lasts (segment-1 field + segment-2 field + 3) quanta. Quantum 0 is the sync segment, and `bit_start` is high on the first clock of every bit.
- R3: Segment 1 occupies quanta 1 to segment-1 field + 1. `sample_pt` is high on the last clock of that last quantum, always together with `tq_tick`.
- R4: `next_ready` is high on the clock that directly follows a `sample_pt` clock, and at no other time.
- R5: A write is taken only in a cycle where `wr_en`, `cfg_unlock` and `init` are all 1. Any other write leaves the timing unchanged.
- R6: While `init` is 1, no strobe is raised and the counters are held at zero. Clearing `init` with `run` at 1 starts a new bit on the first clock.
- R7: After reset all strobes are 0, and the fields hold prescaler 1, segment-1 5 and segment-2 2. This gives a 20-clock bit.
- R8: While `run` is 0, no strobe is raised. Raising `run` again starts a new bit from the sync segment, even if the previous bit was cut short.
- R9: Fields written during init govern the first bit, and every later bit, after init is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the timing fields |
| wr_presc | input | 5 | Prescaler field to write |
| wr_seg1 | input | 5 | Segment-1 field to write |
| wr_seg2 | input | 4 | Segment-2 field to write |
| cfg_unlock | input | 1 | Configuration-change enable |
| init | input | 1 | Initialisation mode; holds the timing |
| run | input | 1 | Run enable |
| tq_tick | output | 1 | Last clock of each time quantum |
| bit_start | output | 1 | First clock of each bit |
| sample_pt | output | 1 | Sample point, at the end of segment 1 |
| next_ready | output | 1 | Next-bit data ready, one clock after the sample point |

## Verification
The bound assertions check, on every cycle, the relations between the strobes:
- silence during init or stop;
- a sample point always on a quantum tick;
- next-ready exactly one clock after a sample point;
- a bit start only after a closing tick;
- the fields frozen unless the triple write condition holds.

Absolute placement depends on the field values, so only the bench scenarios can show it. That covers the tick spacing at prescaler 0 and 31, the bit length at the smallest and largest segment fields, the sample quantum, and restarts after a cut-short bit. The rejected writes, made while locked or while running, are also shown only by the bench, through the unchanged timing that follows them.

// File: rtl/can_bittime_gen.sv
module can_bittime_gen #(
  parameter int PW     = 5,
  parameter int S1W    = 5,
  parameter int S2W    = 4,
  parameter int P_RST  = 1,
  parameter int S1_RST = 5,
  parameter int S2_RST = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [PW-1:0]  wr_presc,
  input  logic [S1W-1:0] wr_seg1,
  input  logic [S2W-1:0] wr_seg2,
  input  logic           cfg_unlock,
  input  logic           init,
  input  logic           run,
  output logic           tq_tick,
  output logic           bit_start,
  output logic           sample_pt,
  output logic           next_ready
);
  localparam int LMAX = (1 << S1W) + (1 << S2W) + 1;
  localparam int QW   = $clog2(LMAX);

  logic [PW-1:0]  presc_q;
  logic [S1W-1:0] seg1_q;
  logic [S2W-1:0] seg2_q;
  logic [PW-1:0]  pc;
  logic [QW-1:0]  qc;
  logic           nr_q;
  logic           active;
  logic           wr_ok;
  logic [QW-1:0]  q_last;
  logic [QW-1:0]  q_samp;

  assign active = run & ~init;
  assign wr_ok  = wr_en & cfg_unlock & init;
  assign q_last = QW'(seg1_q) + QW'(seg2_q) + QW'(2);
  assign q_samp = QW'(seg1_q) + QW'(1);

  assign tq_tick    = active & (pc == presc_q);
  assign bit_start  = active & (pc == '0) & (qc == '0);
  assign sample_pt  = tq_tick & (qc == q_samp);
  assign next_ready = active & nr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= PW'(P_RST);
      seg1_q  <= S1W'(S1_RST);
      seg2_q  <= S2W'(S2_RST);
    end else if (wr_ok) begin
      presc_q <= wr_presc;
      seg1_q  <= wr_seg1;
      seg2_q  <= wr_seg2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      qc   <= '0;
      nr_q <= 1'b0;
    end else if (!active) begin
      pc   <= '0;
      qc   <= '0;
      nr_q <= 1'b0;
    end else begin
      nr_q <= sample_pt;
      if (pc == presc_q) begin
        pc <= '0;
        qc <= (qc == q_last) ? '0 : qc + QW'(1);
      end else begin
        pc <= pc + PW'(1);
      end
    end
  end
endmodule

// File: rtl/can_bittime_chk.sv
module can_bittime_chk #(
  parameter int PW  = 5,
  parameter int S1W = 5,
  parameter int S2W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           cfg_unlock,
  input logic           init,
  input logic           run,
  input logic           tq_tick,
  input logic           bit_start,
  input logic           sample_pt,
  input logic           next_ready,
  input logic [PW-1:0]  presc,
  input logic [S1W-1:0] seg1,
  input logic [S2W-1:0] seg2
);
  a_r6_quiet_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    init |-> !(tq_tick || bit_start || sample_pt || next_ready));

  a_r8_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(tq_tick || bit_start || sample_pt || next_ready));

  a_r3_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |-> tq_tick);

  a_r4_ready_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |=> (next_ready || init || !run));

  a_r4_ready_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    next_ready |-> $past(sample_pt));

  a_r2_start_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start && $past(run && !init)) |-> $past(tq_tick));

  a_r5_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cfg_unlock && init) |=> ($stable(presc) && $stable(seg1) && $stable(seg2)));
endmodule

bind can_bittime_gen can_bittime_chk #(.PW(PW), .S1W(S1W), .S2W(S2W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_unlock(cfg_unlock),
  .init(init), .run(run), .tq_tick(tq_tick), .bit_start(bit_start),
  .sample_pt(sample_pt), .next_ready(next_ready),
  .presc(presc_q), .seg1(seg1_q), .seg2(seg2_q)
);

// File: tb/sim_can_bittime_gen.sv
module sim_can_bittime_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_presc = '0;
  logic [4:0] wr_seg1 = '0;
  logic [3:0] wr_seg2 = '0;
  logic cfg_unlock = 1'b0;
  logic init = 1'b1;
  logic run = 1'b0;
  logic tq_tick, bit_start, sample_pt, next_ready;

  always #2 clk = ~clk;

  can_bittime_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_presc(wr_presc),
    .wr_seg1(wr_seg1), .wr_seg2(wr_seg2), .cfg_unlock(cfg_unlock),
    .init(init), .run(run), .tq_tick(tq_tick), .bit_start(bit_start),
    .sample_pt(sample_pt), .next_ready(next_ready)
  );

  typedef struct {
    int         cyc;
    logic [3:0] vec;
    string      tag;
  } ev_t;

  ev_t   exp_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  string idle_tag = "R6 R8 idle";
  int    m_p = 1, m_s1 = 5, m_s2 = 2;

  // strobe vector order: {bit_start, sample_pt, next_ready, tq_tick}
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] obs;
      ev_t e;
      obs = {bit_start, sample_pt, next_ready, tq_tick};
      while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
        e = exp_q.pop_front();
        checks++; errors++;
        $display("FAIL %s missing event at cycle %0d: actual none expected %b", e.tag, e.cyc, e.vec);
      end
      if (obs != 4'b0) begin
        checks++;
        if (exp_q.size() == 0 || exp_q[0].cyc != cyc) begin
          errors++;
          $display("FAIL %s unexpected strobes at cycle %0d: actual %b expected 0000", idle_tag, cyc, obs);
        end else begin
          e = exp_q.pop_front();
          if (e.vec != obs) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %b expected %b", e.tag, cyc, obs, e.vec);
          end
        end
      end
      cyc++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic write_cfg(input int p, input int s1, input int s2, input bit unl, input bit ini);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_presc = 5'(p); wr_seg1 = 5'(s1); wr_seg2 = 4'(s2);
    cfg_unlock = unl; init = ini;
    if (unl && ini) begin m_p = p; m_s1 = s1; m_s2 = s2; end
    @(posedge clk); #1;
    wr_en = 1'b0; cfg_unlock = 1'b0;
  endtask

  // mode 0: start/stop by run; mode 1: start/stop by init with run held high
  task automatic go(input int n, input string tag, input bit mode);
    int q, l, b, base, u, p, qi;
    ev_t e;
    q = m_p + 1; l = m_s1 + m_s2 + 3; b = q * l;
    @(posedge clk); #1;
    if (mode) init = 1'b0; else begin init = 1'b0; run = 1'b1; end
    base = cyc;
    for (int t = 0; t < n; t++) begin
      logic [3:0] v;
      u = t % b; qi = u / q; p = u % q;
      v[0] = (p == q - 1);
      v[3] = (u == 0);
      v[2] = v[0] && (qi == m_s1 + 1);
      v[1] = (t >= 1) && (((t - 1) % b) == (m_s1 + 2) * q - 1);
      if (v != 4'b0) begin
        e.cyc = base + t; e.vec = v; e.tag = tag;
        exp_q.push_back(e);
      end
    end
    repeat (n) @(posedge clk);
    #1;
    if (mode) init = 1'b1; else run = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({bit_start, sample_pt, next_ready, tq_tick} == 4'b0, "R7 strobes in reset",
        int'({bit_start, sample_pt, next_ready, tq_tick}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    run = 1'b1;
    repeat (5) @(negedge clk);
    chk({bit_start, sample_pt, next_ready, tq_tick} == 4'b0, "R6 init with run high",
        int'({bit_start, sample_pt, next_ready, tq_tick}), 0);
    @(posedge clk); #1 run = 1'b0; init = 1'b0;

    // R7 default fields: 2-clock quanta, 10 quanta per bit
    go(40, "R7 R1 R2 R3 R4 default", 1'b0);

    // R9/R1 single-clock quanta
    @(posedge clk); #1 init = 1'b1;
    write_cfg(0, 2, 1, 1'b1, 1'b1);
    go(18, "R9 R1 R2 R3 R4 presc0", 1'b0);

    // R2 smallest segments, 4-clock quanta
    @(posedge clk); #1 init = 1'b1;
    write_cfg(3, 0, 0, 1'b1, 1'b1);
    go(24, "R2 R3 R4 minimal segments", 1'b0);

    // R5 locked write during init: config must stay 3/0/0
    @(posedge clk); #1 init = 1'b1;
    write_cfg(7, 9, 9, 1'b0, 1'b1);
    go(24, "R5 locked write", 1'b0);

    // R5 write with unlock set while running (init low) is ignored
    fork
      go(36, "R5 write while running", 1'b0);
      begin
        repeat (8) @(posedge clk);
        write_cfg(1, 1, 1, 1'b1, 1'b0);
      end
    join

    // R8 run dropped mid-bit, then a fresh bit from the sync segment
    go(5, "R8 cut short", 1'b0);
    go(12, "R8 restart", 1'b0);

    // R6 init raised mid-bit with run held, then released
    @(posedge clk); #1 run = 1'b1; init = 1'b1;
    repeat (3) @(posedge clk);
    go(6, "R6 before init", 1'b1);
    repeat (6) @(posedge clk);
    go(12, "R6 after init release", 1'b1);
    @(posedge clk); #1 run = 1'b0;

    // R1 R2 R9 largest fields: 32-clock quanta, 49 quanta per bit
    @(posedge clk); #1 init = 1'b1;
    write_cfg(31, 31, 15, 1'b1, 1'b1);
    go(1568 + 40, "R1 R2 R9 max fields", 1'b0);

    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R2 R3 all expected strobes seen", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule